// File: doc/BRIEF.md
# Host Bus VRAM Port

This block connects an 8-bit asynchronous host bus to a graphics card. The host bus carries a 3-bit register index, an active-low chip select, active-low read and write strobes, and an active-low stall output. Through this bus the host can reach four things:

- the display controller's command and parameter ports;
- a write-only card setup register;
- a pair of write-only address byte registers;
- a data window onto video memory.

The host strobes are brought into the card clock domain through a synchronizer and edge-detected. Each host access therefore acts once.

A data-window access becomes a request to a single-port memory. Display fetches always take precedence over host requests. The host is held off with the stall line until a write has been performed, or until read data has been latched onto the bus. The 16-bit access address can advance by one at the end of each data-window access, and it wraps past the top. When page flipping is enabled, the address is steered into the memory half that is not on screen.

Top module: `vram_host_port`

## Requirements
- R1: After reset, `bus_wait_n` is 1, `bus_dout` is 0x00, and `cfg_wide`, `cfg_dbuf` and `cfg_disp_sel` are 0.
- R2: A write to index 0 or 1 gives a one-cycle `ctl_wr` pulse, with `ctl_a0` equal to index bit 0 and `ctl_wdata` equal to the written byte. A read of index 0 or 1 gives a one-cycle `ctl_rd` pulse and returns `ctl_rdata` on `bus_dout`.
- R3: Index 2 is the setup register. Bit 0 enables address stepping. Bit 1 drives `cfg_wide`, bit 2 drives `cfg_dbuf`, and bit 7 drives `cfg_disp_sel`, which is the half on screen.
- R4: Index 4 (and its alias 5) loads address bits 7:0. Index 6 (and its alias 7) loads address bits 15:8.
- R5: When setup bit 0 is 1, the address rises by exactly one at the end of each index 3 access, wrapping from 0xFFFF to 0x0000. When setup bit 0 is 0, the address does not change.
- R6: For an index 3 access, `mem_addr[16]` is the inverse of setup bit 7 when setup bit 2 is 1, and 0 when setup bit 2 is 0. `mem_addr[15:0]` is the address register.
- R7: A read of index 2, 4, 5, 6 or 7 returns 0x00.
- R8: `host_mem_en` is never 1 while `disp_req` is 1. A pending index 3 access holds `bus_wait_n` at 0 until it is served.
- R9: `bus_wait_n` goes to 0 only during an index 3 access. Accesses to the other indices leave it at 1, even while the display holds the memory.
- R10: For an index 3 read, the memory byte at the access address is on `bus_dout` by the first cycle in which `bus_wait_n` is back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Host register index |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data |
| bus_sel_n | input | 1 | Host chip select, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_wait_n | output | 1 | Stall to host, active low |
| ctl_wr | output | 1 | Write pulse to display controller |
| ctl_rd | output | 1 | Read pulse to display controller |
| ctl_a0 | output | 1 | Command (0) or parameter (1) select |
| ctl_wdata | output | 8 | Byte to display controller |
| ctl_rdata | input | 8 | Byte from display controller |
| cfg_wide | output | 1 | Two-pixels-per-clock output mode |
| cfg_dbuf | output | 1 | Page flipping enabled |
| cfg_disp_sel | output | 1 | Memory half shown on screen |
| disp_req | input | 1 | Display fetch wants memory this cycle |
| host_mem_en | output | 1 | Host owns the memory port this cycle |
| mem_we | output | 1 | Host memory write enable |
| mem_addr | output | 17 | Host memory byte address |
| mem_wdata | output | 8 | Host memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after enable |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 16-bit access address and a two-stage strobe synchronizer. With these values, the 0xFFFF wrap takes only two loads of the address bytes. The two memory halves are distinguished by bit 16 in a sparse bench memory. A display-request pattern that holds the memory three cycles out of five runs under the vector table, so host requests routinely wait for a free slot. Directed tests then hold the display request high for many cycles, to show stalls on the data window only and read data that is valid as the stall lifts.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

  // Host register indices; 5 and 7 mirror 4 and 6
  typedef enum logic [2:0] {
    IX_CMD    = 3'd0,
    IX_PARAM  = 3'd1,
    IX_SETUP  = 3'd2,
    IX_WINDOW = 3'd3,
    IX_ALO    = 3'd4,
    IX_ALO_M  = 3'd5,
    IX_AHI    = 3'd6,
    IX_AHI_M  = 3'd7
  } host_ix_e;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_PEND = 2'd1,
    ARB_CAPT = 2'd2
  } arb_st_e;

  localparam int SETUP_STEP = 0;
  localparam int SETUP_WIDE = 1;
  localparam int SETUP_FLIP = 2;
  localparam int SETUP_SHOW = 7;

endpackage

// File: rtl/vhp_sync.sv
module vhp_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/vhp_arb.sv
module vhp_arb
  import vhp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              disp_req,
  output logic              host_mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pend,
  output logic              capt,
  output logic              idle
);

  arb_st_e           st;
  logic              we_q;
  logic [MEM_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // Host gets the port only in a cycle the display leaves free
  assign pend        = (st == ARB_PEND);
  assign capt        = (st == ARB_CAPT);
  assign idle        = (st == ARB_IDLE);
  assign host_mem_en = pend & ~disp_req;
  assign mem_we      = we_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ARB_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st)
        ARB_IDLE: if (req) begin
          st      <= ARB_PEND;
          we_q    <= req_we;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        ARB_PEND: if (!disp_req) st <= we_q ? ARB_IDLE : ARB_CAPT;
        ARB_CAPT: st <= ARB_IDLE;
        default:  st <= ARB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
  import vhp_pkg::*;
#(
  parameter  int DATA_W      = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = 2 * DATA_W,
  localparam int MEM_AW      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  input  logic              bus_sel_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  output logic              bus_wait_n,
  output logic              ctl_wr,
  output logic              ctl_rd,
  output logic              ctl_a0,
  output logic [DATA_W-1:0] ctl_wdata,
  input  logic [DATA_W-1:0] ctl_rdata,
  output logic              cfg_wide,
  output logic              cfg_dbuf,
  output logic              cfg_disp_sel,
  input  logic              disp_req,
  output logic              host_mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [2:0]        strb_s;
  logic              rd_act, wr_act, rd_act_q, wr_act_q;
  logic              rd_go, wr_go, acc_end;
  logic              step_en, acc_vram_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              addr_byte_wr;
  logic              arb_req, arb_pend, arb_capt, arb_idle;
  logic [MEM_AW-1:0] req_addr;
  host_ix_e          ix;

  vhp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_sel_n, bus_rd_n, bus_wr_n}),
    .q   (strb_s)
  );

  assign ix      = host_ix_e'(bus_addr);
  assign rd_act  = ~strb_s[2] & ~strb_s[1];
  assign wr_act  = ~strb_s[2] & ~strb_s[0];
  assign rd_go   = rd_act & ~rd_act_q;
  assign wr_go   = wr_act & ~wr_act_q;
  assign acc_end = (rd_act_q | wr_act_q) & ~(rd_act | wr_act);

  assign addr_byte_wr = wr_go & bus_addr[2];
  assign arb_req      = (rd_go | wr_go) & (ix == IX_WINDOW);
  assign req_addr     = {cfg_dbuf & ~cfg_disp_sel, vaddr_q};
  assign bus_wait_n   = arb_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q     <= 1'b0;
      wr_act_q     <= 1'b0;
      step_en      <= 1'b0;
      cfg_wide     <= 1'b0;
      cfg_dbuf     <= 1'b0;
      cfg_disp_sel <= 1'b0;
      vaddr_q      <= '0;
      acc_vram_q   <= 1'b0;
      ctl_wr       <= 1'b0;
      ctl_rd       <= 1'b0;
      ctl_a0       <= 1'b0;
      ctl_wdata    <= '0;
      bus_dout     <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      ctl_wr   <= 1'b0;
      ctl_rd   <= 1'b0;
      if (rd_go | wr_go) acc_vram_q <= (ix == IX_WINDOW);
      if (wr_go) begin
        unique case (ix)
          IX_CMD, IX_PARAM: begin
            ctl_wr    <= 1'b1;
            ctl_a0    <= bus_addr[0];
            ctl_wdata <= bus_din;
          end
          IX_SETUP: begin
            step_en      <= bus_din[SETUP_STEP];
            cfg_wide     <= bus_din[SETUP_WIDE];
            cfg_dbuf     <= bus_din[SETUP_FLIP];
            cfg_disp_sel <= bus_din[SETUP_SHOW];
          end
          IX_ALO, IX_ALO_M: vaddr_q[DATA_W-1:0]      <= bus_din;
          IX_AHI, IX_AHI_M: vaddr_q[ADDR_W-1:DATA_W] <= bus_din;
          default: ;
        endcase
      end
      if (rd_go) begin
        unique case (ix)
          IX_CMD, IX_PARAM: begin
            ctl_rd   <= 1'b1;
            ctl_a0   <= bus_addr[0];
            bus_dout <= ctl_rdata;
          end
          IX_WINDOW: ;
          default:  bus_dout <= '0;
        endcase
      end
      if (arb_capt) bus_dout <= mem_rdata;
      if (acc_end && acc_vram_q && step_en) vaddr_q <= vaddr_q + 1'b1;
    end
  end

  vhp_arb #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .req         (arb_req),
    .req_we      (wr_go),
    .req_addr    (req_addr),
    .req_wdata   (bus_din),
    .disp_req    (disp_req),
    .host_mem_en (host_mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .pend        (arb_pend),
    .capt        (arb_capt),
    .idle        (arb_idle)
  );

endmodule

// File: rtl/vhp_checker.sv
module vhp_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              disp_req,
  input logic              host_mem_en,
  input logic [ADDR_W:0]   mem_addr,
  input logic              cfg_dbuf,
  input logic              cfg_disp_sel,
  input logic              bus_wait_n,
  input logic              ctl_wr,
  input logic              arb_pend,
  input logic              acc_vram_q,
  input logic [ADDR_W-1:0] vaddr_q,
  input logic              addr_byte_wr
);

  // R8: display fetch always wins the memory port
  p_disp_first_r8: assert property (@(posedge clk) disable iff (rst)
    disp_req |-> !host_mem_en);

  // R8: a waiting host request keeps the host stalled while the display holds memory
  p_stall_held_r8: assert property (@(posedge clk) disable iff (rst)
    (arb_pend && disp_req) |=> !bus_wait_n);

  // R9: stall only belongs to a data-window access
  p_wait_window_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_wait_n |-> acc_vram_q);

  // R6: page flipping steers host to the hidden half
  p_hidden_half_r6: assert property (@(posedge clk) disable iff (rst)
    (host_mem_en && cfg_dbuf) |-> (mem_addr[ADDR_W] == !cfg_disp_sel));

  p_flat_half_r6: assert property (@(posedge clk) disable iff (rst)
    (host_mem_en && !cfg_dbuf) |-> !mem_addr[ADDR_W]);

  // R2: controller write strobe lasts one cycle
  p_ctl_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !ctl_wr);

  // R5: address moves only by one step or by a byte load
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (vaddr_q != $past(vaddr_q)) |->
      ((vaddr_q == ADDR_W'($past(vaddr_q) + 1'b1)) || $past(addr_byte_wr)));

endmodule

bind vram_host_port vhp_checker #(.ADDR_W(ADDR_W)) u_vhp_checker (
  .clk          (clk),
  .rst          (rst),
  .disp_req     (disp_req),
  .host_mem_en  (host_mem_en),
  .mem_addr     (mem_addr),
  .cfg_dbuf     (cfg_dbuf),
  .cfg_disp_sel (cfg_disp_sel),
  .bus_wait_n   (bus_wait_n),
  .ctl_wr       (ctl_wr),
  .arb_pend     (arb_pend),
  .acc_vram_q   (acc_vram_q),
  .vaddr_q      (vaddr_q),
  .addr_byte_wr (addr_byte_wr)
);

// File: tb/vram_host_port_bench.sv
module vram_host_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = 3'd0;
  logic [7:0]  bus_din = 8'h00;
  logic [7:0]  bus_dout;
  logic        bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic        bus_wait_n;
  logic        ctl_wr, ctl_rd, ctl_a0;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_rdata = 8'hC4;
  logic        cfg_wide, cfg_dbuf, cfg_disp_sel;
  logic        disp_req = 1'b0;
  logic        host_mem_en, mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  always #2.5 clk = ~clk;

  vram_host_port u_vram_host_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wait_n(bus_wait_n),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_a0(ctl_a0), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cfg_wide(cfg_wide), .cfg_dbuf(cfg_dbuf),
    .cfg_disp_sel(cfg_disp_sel), .disp_req(disp_req), .host_mem_en(host_mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Sparse memory model with one-cycle read latency
  logic [7:0] vmem [int unsigned];
  int unsigned collide = 0, cw_cnt = 0, cr_cnt = 0;
  logic [8:0]  cw_last = '0;
  logic        cr_a0 = 1'b0;
  always @(posedge clk) begin
    if (host_mem_en) begin
      if (mem_we) vmem[{15'd0, mem_addr}] = mem_wdata;
      else        mem_rdata <= vmem.exists({15'd0, mem_addr}) ? vmem[{15'd0, mem_addr}] : 8'h00;
    end
    if (host_mem_en && disp_req) collide++;
    if (ctl_wr) begin cw_cnt++; cw_last = {ctl_a0, ctl_wdata}; end
    if (ctl_rd) begin cr_cnt++; cr_a0 = ctl_a0; end
  end

  // Display request pattern: busy three cycles out of five, or forced
  bit disp_force = 1'b0, disp_pat = 1'b0, wait_low_seen = 1'b0;
  int unsigned cyc = 0;
  always @(negedge clk) begin
    cyc++;
    disp_req = disp_force | (disp_pat && (cyc % 5) < 3);
    if (!bus_wait_n) wait_low_seen = 1'b1;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] vm(input int unsigned a);
    return vmem.exists(a) ? vmem[a] : 8'h00;
  endfunction

  task automatic bus_xfer(input bit wr, input logic [2:0] ix, input logic [7:0] d,
                          output logic [7:0] q);
    @(negedge clk); bus_addr = ix; bus_din = d; bus_sel_n = 1'b0;
    @(negedge clk); if (wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    while (!bus_wait_n) @(negedge clk);
    q = bus_dout;
    bus_wr_n = 1'b1; bus_rd_n = 1'b1;
    @(negedge clk); bus_sel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] ix, input logic [7:0] d);
    logic [7:0] dummy;
    bus_xfer(1'b1, ix, d, dummy);
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(3'd4, a[7:0]);
    wr(3'd6, a[15:8]);
  endtask

  // {is_write, index, data, expected, checked}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 3'd2, 8'h01, 8'h00, 1'b0},
    {1'b1, 3'd4, 8'h10, 8'h00, 1'b0},
    {1'b1, 3'd6, 8'h00, 8'h00, 1'b0},
    {1'b1, 3'd3, 8'hA5, 8'h00, 1'b0},
    {1'b1, 3'd3, 8'h5A, 8'h00, 1'b0},
    {1'b1, 3'd5, 8'h10, 8'h00, 1'b0},
    {1'b0, 3'd3, 8'h00, 8'hA5, 1'b1},
    {1'b0, 3'd3, 8'h00, 8'h5A, 1'b1},
    {1'b0, 3'd2, 8'h00, 8'h00, 1'b1},
    {1'b0, 3'd4, 8'h00, 8'h00, 1'b1},
    {1'b0, 3'd7, 8'h00, 8'h00, 1'b1},
    {1'b1, 3'd7, 8'h12, 8'h00, 1'b0},
    {1'b1, 3'd3, 8'hC3, 8'h00, 1'b0},
    {1'b1, 3'd4, 8'h12, 8'h00, 1'b0},
    {1'b0, 3'd3, 8'h00, 8'hC3, 1'b1}
  };

  initial begin
    logic [7:0] q;
    int unsigned c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 wait_n", {16'd0, bus_wait_n}, 17'd1);
    chk("R1 dout", {9'd0, bus_dout}, 17'd0);
    chk("R1 cfg_wide", {16'd0, cfg_wide}, 17'd0);
    chk("R1 cfg_dbuf", {16'd0, cfg_dbuf}, 17'd0);
    chk("R1 cfg_disp_sel", {16'd0, cfg_disp_sel}, 17'd0);

    // Table walk under a busy display (R4 R5 R7 R10)
    disp_pat = 1'b1;
    for (int i = 0; i < NV; i++) begin
      bus_xfer(VEC[i][20], VEC[i][19:17], VEC[i][16:9], q);
      if (VEC[i][0]) chk($sformatf("R4/R5/R7/R10 vector %0d", i), {9'd0, q}, {9'd0, VEC[i][8:1]});
    end
    disp_pat = 1'b0;

    // R2 controller pass-through
    c0 = cw_cnt;
    wr(3'd1, 8'h6F);
    chk("R2 param write count", 17'(cw_cnt - c0), 17'd1);
    chk("R2 param write a0/data", {8'd0, cw_last}, {8'd0, 1'b1, 8'h6F});
    wr(3'd0, 8'h47);
    chk("R2 command write a0/data", {8'd0, cw_last}, {8'd0, 1'b0, 8'h47});
    c0 = cr_cnt;
    bus_xfer(1'b0, 3'd0, 8'h00, q);
    chk("R2 command read data", {9'd0, q}, {9'd0, 8'hC4});
    chk("R2 command read count", 17'(cr_cnt - c0), 17'd1);
    chk("R2 command read a0", {16'd0, cr_a0}, 17'd0);

    // R3 setup bits
    wr(3'd2, 8'h86);
    chk("R3 wide", {16'd0, cfg_wide}, 17'd1);
    chk("R3 flip", {16'd0, cfg_dbuf}, 17'd1);
    chk("R3 show", {16'd0, cfg_disp_sel}, 17'd1);

    // R6 page flipping: half 0 shown -> write to half 1
    wr(3'd2, 8'h05);
    set_addr(16'h0040);
    wr(3'd3, 8'h99);
    chk("R6 hidden half 1", {9'd0, vm(32'h10040)}, {9'd0, 8'h99});
    chk("R6 shown half 0 untouched", {16'd0, 1'(vmem.exists(32'h00040))}, 17'd0);
    wr(3'd2, 8'h85);
    set_addr(16'h0040);
    wr(3'd3, 8'h66);
    chk("R6 hidden half 0", {9'd0, vm(32'h00040)}, {9'd0, 8'h66});
    set_addr(16'h0040);
    bus_xfer(1'b0, 3'd3, 8'h00, q);
    chk("R6 read from hidden half", {9'd0, q}, {9'd0, 8'h66});

    // R5 wrap
    wr(3'd2, 8'h01);
    set_addr(16'hFFFF);
    wr(3'd3, 8'h77);
    wr(3'd3, 8'h88);
    chk("R5 top byte", {9'd0, vm(32'h0FFFF)}, {9'd0, 8'h77});
    chk("R5 wrap to zero", {9'd0, vm(32'h00000)}, {9'd0, 8'h88});

    // R5 stepping off
    wr(3'd2, 8'h00);
    set_addr(16'h0300);
    wr(3'd3, 8'h11);
    wr(3'd3, 8'h22);
    wr(3'd3, 8'h33);
    chk("R5 no step last write", {9'd0, vm(32'h00300)}, {9'd0, 8'h33});
    chk("R5 no step next empty", {16'd0, 1'(vmem.exists(32'h00301))}, 17'd0);

    // R8 write stalled by display
    disp_force = 1'b1;
    fork
      begin
        repeat (15) @(negedge clk);
        chk("R8 stalled wait_n", {16'd0, bus_wait_n}, 17'd0);
        chk("R8 no write while stalled", {9'd0, vm(32'h00300)}, {9'd0, 8'h33});
        disp_force = 1'b0;
      end
    join_none
    wr(3'd3, 8'h44);
    chk("R8 write after release", {9'd0, vm(32'h00300)}, {9'd0, 8'h44});

    // R10 stalled read: data valid as stall lifts
    disp_force = 1'b1;
    wait_low_seen = 1'b0;
    fork
      begin
        repeat (15) @(negedge clk);
        disp_force = 1'b0;
      end
    join_none
    bus_xfer(1'b0, 3'd3, 8'h00, q);
    chk("R10 data at stall release", {9'd0, q}, {9'd0, 8'h44});
    chk("R8 stall seen on read", {16'd0, wait_low_seen}, 17'd1);

    // R9 no stall on other indices
    disp_force = 1'b1;
    repeat (2) @(negedge clk);
    wait_low_seen = 1'b0;
    wr(3'd2, 8'h00);
    bus_xfer(1'b0, 3'd4, 8'h00, q);
    wr(3'd1, 8'h0D);
    chk("R9 no stall off window", {16'd0, wait_low_seen}, 17'd0);
    chk("R7 address reg reads zero", {9'd0, q}, 17'd0);
    disp_force = 1'b0;

    chk("R8 no host grant during display", 17'(collide), 17'd0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule